// File: doc/BRIEF.md
# DMA Burst Length and Completion Controller

This block sits between the command decoder that launches a transfer-information command and the DMA engine that moves the bytes. It takes the two transfer-count byte registers and a signed count of bytes still expected in the current bus phase. From these it works out how long the next DMA burst may be, which way the data flows and how many bytes of the transfer are still outstanding. A negative phase count means the data goes to the target, and a positive one means it comes from the target.

When the engine reports a finished burst, the block steps its counters down. It then either completes the transfer at once or holds completion until the device side reports that it has finished. On completion it issues a one-cycle pulse. The pulse carries the register updates the host-visible file must apply: set transfer-complete in status, write the bus-service interrupt code, and clear sequence step, FIFO flags and both transfer-count bytes.

Top module: `dma_len_ctrl`

## Requirements
- R1: The DMA length is `{tc_mid_i, tc_lo_i}` as a 16-bit value. A value of zero stands for 65536. After an accepted start, `xfer_count_o` holds this length.
- R2: When `cmd_phase_i` is high, `burst_len_o` is the smaller of the DMA length and 32, and the direction is toward the device.
- R3: When `cmd_phase_i` is low, `burst_len_o` is the smaller of the DMA length and the magnitude of the phase count. `dir_to_dev` is 1 exactly when the phase count is negative.
- R4: An accepted start registers the following one cycle later: `bytes_left_o` = burst length, `xfer_count_o` = DMA length and `dir_to_dev_o` = direction. In that same cycle `stat_tc_clr_o` pulses high for one cycle and `busy_o` rises.
- R5: A start strobe while `busy_o` is high has no effect on `bytes_left_o`, `xfer_count_o` or `stat_tc_clr_o`.
- R6: Each accepted `burst_done_i` lowers `bytes_left_o` by `burst_step_i` and stops at zero. Outside the command phase, the phase count moves toward zero by the same amount and stops at zero. In the command phase the phase count is left unchanged.
- R7: After a burst, completion follows in the next cycle if any of these holds: the direction is toward the device, bytes left is nonzero, or the phase count is zero. Otherwise completion follows the cycle after `dev_finished_i`.
- R8: Completion is a one-cycle `done_o` pulse. In that cycle `stat_tc_set_o` = 1, `intr_code_o` = 8'h10 (bus service) and `zero_regs_o` = 4'b1111 (bit0 sequence step, bit1 FIFO flags, bit2 count low, bit3 count middle). In the next cycle all of these are zero.
- R9: After reset, all counters are zero, `busy_o` and `done_o` are low, and the status strobes are low.
- R10: `phase_load_i` writes `phase_val_i` into the phase count, and the value is visible on `phase_count_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tc_lo_i | input | 8 | Transfer-count low byte |
| tc_mid_i | input | 8 | Transfer-count middle byte |
| cmd_phase_i | input | 1 | High when the transfer carries command bytes |
| phase_load_i | input | 1 | Load the phase count |
| phase_val_i | input | 24 | Signed phase count to load |
| start_i | input | 1 | Transfer-information start strobe |
| burst_done_i | input | 1 | DMA engine finished a burst |
| burst_step_i | input | 17 | Bytes moved by that burst |
| dev_finished_i | input | 1 | Device side reports it has finished |
| burst_len_o | output | 17 | Burst length for the current inputs |
| dir_to_dev_o | output | 1 | Latched direction, 1 = toward the device |
| xfer_count_o | output | 17 | Latched DMA length |
| bytes_left_o | output | 17 | Bytes outstanding in the current burst |
| phase_count_o | output | 24 | Signed remaining phase count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| stat_tc_set_o | output | 1 | Set transfer-complete in status |
| stat_tc_clr_o | output | 1 | Clear transfer-complete in status |
| intr_code_o | output | 8 | Interrupt code to write at completion |
| zero_regs_o | output | 4 | Registers to clear at completion |

## Verification
`burst_len_o` is combinational. It is checked in the cycle after the phase count is loaded, once the inputs have settled. The start results (`xfer_count_o`, `bytes_left_o`, `dir_to_dev_o`, `stat_tc_clr_o`) are due one edge after the start strobe. The stepped counters and an immediate `done_o` are due one edge after `burst_done_i`, and a deferred `done_o` is due one edge after `dev_finished_i`. The bench drives inputs on the falling edge and reads each result on the falling edge that follows the rising edge where that result is due.

// File: rtl/dma_len_pkg.sv
// Shared types and constants for the DMA length and completion controller.
package dma_len_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_WAIT} xfer_state_t;
    localparam logic [7:0] INTR_BUS_SERVICE = 8'h10;
    localparam int         NUM_ZERO_REGS    = 4;
endpackage

// File: rtl/dlc_burst_len.sv
// Burst length calculator.
// Builds the DMA length from the two count bytes, treating zero as the full
// range. It then clamps that length to the command cap or to the magnitude
// of the signed phase count. Purely combinational; the clock is used only
// by the assertions.
module dlc_burst_len #(
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 24,
    parameter int CMD_MAX = 32,
    localparam int LEN_W  = 2 * BYTE_W + 1,
    localparam int CW     = (LEN_W > PHASE_W) ? LEN_W : PHASE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BYTE_W-1:0]         tc_lo_i,
    input  logic [BYTE_W-1:0]         tc_mid_i,
    input  logic                      cmd_phase_i,
    input  logic signed [PHASE_W-1:0] phase_cnt_i,
    output logic [LEN_W-1:0]          dma_len_o,
    output logic [LEN_W-1:0]          burst_len_o,
    output logic                      to_dev_o
);
    logic [2*BYTE_W-1:0] raw;
    logic [PHASE_W-1:0]  mag;
    logic [CW-1:0]       dma_ext, limit_ext;

    // Compute DMA length, clamp limit, burst length and direction.
    always_comb begin
        raw       = {tc_mid_i, tc_lo_i};
        dma_len_o = (raw == '0) ? LEN_W'(1) << (2 * BYTE_W) : {1'b0, raw};
        mag       = phase_cnt_i[PHASE_W-1] ? PHASE_W'(-phase_cnt_i) : PHASE_W'(phase_cnt_i);
        dma_ext   = CW'(dma_len_o);
        limit_ext = cmd_phase_i ? CW'(CMD_MAX) : CW'(mag);
        burst_len_o = (dma_ext < limit_ext) ? dma_len_o : LEN_W'(limit_ext);
        to_dev_o  = cmd_phase_i | phase_cnt_i[PHASE_W-1];
    end

    assert_burst_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_phase_i |-> (CW'(burst_len_o) <= CW'(CMD_MAX)));
    assert_burst_le_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_len_o <= dma_len_o);
endmodule

// File: rtl/dlc_counters.sv
// Transfer counters.
// Holds the latched DMA length, the bytes left in the burst, the signed
// phase count and the latched direction. Assumes start_acc_i and
// burst_acc_i are never high together (the controller guarantees this).
module dlc_counters #(
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 24,
    localparam int LEN_W  = 2 * BYTE_W + 1,
    localparam int CW     = (LEN_W > PHASE_W) ? LEN_W : PHASE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      phase_load_i,
    input  logic signed [PHASE_W-1:0] phase_val_i,
    input  logic                      start_acc_i,
    input  logic                      burst_acc_i,
    input  logic [LEN_W-1:0]          dma_len_i,
    input  logic [LEN_W-1:0]          burst_len_i,
    input  logic                      to_dev_i,
    input  logic                      cmd_i,
    input  logic [LEN_W-1:0]          step_i,
    output logic [LEN_W-1:0]          xfer_count_o,
    output logic [LEN_W-1:0]          bytes_left_o,
    output logic signed [PHASE_W-1:0] phase_cnt_o,
    output logic                      dir_to_dev_o,
    output logic [LEN_W-1:0]          left_next_o,
    output logic                      phase_next_zero_o
);
    logic                      cmd_q;
    logic [PHASE_W-1:0]        mag;
    logic signed [PHASE_W-1:0] step_p, phase_next;
    logic                      step_covers;

    // Next bytes-left and next phase count after a burst of step_i bytes.
    always_comb begin
        left_next_o = (step_i >= bytes_left_o) ? '0 : bytes_left_o - step_i;
        mag         = phase_cnt_o[PHASE_W-1] ? PHASE_W'(-phase_cnt_o) : PHASE_W'(phase_cnt_o);
        step_p      = signed'(PHASE_W'(step_i));
        step_covers = CW'(step_i) >= CW'(mag);
        if (cmd_q)
            phase_next = phase_cnt_o;
        else if (step_covers)
            phase_next = '0;
        else if (phase_cnt_o[PHASE_W-1])
            phase_next = phase_cnt_o + step_p;
        else
            phase_next = phase_cnt_o - step_p;
        phase_next_zero_o = (phase_next == '0);
    end

    // Latch length, burst and direction on start; step bytes-left per burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_count_o <= '0;
            bytes_left_o <= '0;
            dir_to_dev_o <= 1'b0;
            cmd_q        <= 1'b0;
        end else if (start_acc_i) begin
            xfer_count_o <= dma_len_i;
            bytes_left_o <= burst_len_i;
            dir_to_dev_o <= to_dev_i;
            cmd_q        <= cmd_i;
        end else if (burst_acc_i) begin
            bytes_left_o <= left_next_o;
        end
    end

    // Phase count: a burst step takes priority over a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_cnt_o <= '0;
        else if (burst_acc_i)
            phase_cnt_o <= phase_next;
        else if (phase_load_i)
            phase_cnt_o <= phase_val_i;
    end

    assert_left_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_acc_i |=> (bytes_left_o <= $past(bytes_left_o)));
    assert_phase_toward_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_acc_i && !phase_load_i) |=> (mag <= $past(mag)));
    assert_no_start_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_acc_i && burst_acc_i));
endmodule

// File: rtl/dlc_complete.sv
// Completion controller.
// Sequences idle, transfer and wait-for-device. It decides whether a
// finished burst completes at once or waits for the device, and issues
// the registered status, interrupt and clear strobes.
module dlc_complete
    import dma_len_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int LEN_W = 2 * BYTE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     burst_done_i,
    input  logic                     dev_finished_i,
    input  logic                     dir_to_dev_i,
    input  logic [LEN_W-1:0]         left_next_i,
    input  logic                     phase_next_zero_i,
    output logic                     start_acc_o,
    output logic                     burst_acc_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     stat_tc_set_o,
    output logic                     stat_tc_clr_o,
    output logic [7:0]               intr_code_o,
    output logic [NUM_ZERO_REGS-1:0] zero_regs_o
);
    xfer_state_t state_q, state_d;
    logic finish_now, defer, wait_end;
    logic done_q, clr_q;

    // Accept strobes by state and choose immediate or deferred completion.
    always_comb begin
        start_acc_o = start_i && (state_q == ST_IDLE);
        burst_acc_o = burst_done_i && (state_q == ST_XFER);
        finish_now  = burst_acc_o && (dir_to_dev_i || (left_next_i != '0) || phase_next_zero_i);
        defer       = burst_acc_o && !finish_now;
        wait_end    = (state_q == ST_WAIT) && dev_finished_i;
        state_d     = state_q;
        case (state_q)
            ST_IDLE: if (start_acc_o) state_d = ST_XFER;
            ST_XFER: if (finish_now) state_d = ST_IDLE;
                     else if (defer) state_d = ST_WAIT;
            ST_WAIT: if (wait_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and registered completion and start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish_now || wait_end;
            clr_q   <= start_acc_o;
        end
    end

    // Drive the register update outputs from the strobes.
    always_comb begin
        busy_o        = (state_q != ST_IDLE);
        done_o        = done_q;
        stat_tc_set_o = done_q;
        stat_tc_clr_o = clr_q;
        intr_code_o   = done_q ? INTR_BUS_SERVICE : 8'h00;
        zero_regs_o   = done_q ? {NUM_ZERO_REGS{1'b1}} : '0;
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_set_clr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_tc_set_o && stat_tc_clr_o));
    assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !dev_finished_i) |=> !done_o);
    assert_done_from_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));
endmodule

// File: rtl/dma_len_ctrl.sv
// DMA length and completion controller, top level.
// Wires the burst-length calculator, the counters and the completion
// controller. Assumes phase_load_i is used only while idle.
module dma_len_ctrl
    import dma_len_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 24,
    parameter int CMD_MAX = 32,
    localparam int LEN_W  = 2 * BYTE_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BYTE_W-1:0]         tc_lo_i,
    input  logic [BYTE_W-1:0]         tc_mid_i,
    input  logic                      cmd_phase_i,
    input  logic                      phase_load_i,
    input  logic signed [PHASE_W-1:0] phase_val_i,
    input  logic                      start_i,
    input  logic                      burst_done_i,
    input  logic [LEN_W-1:0]          burst_step_i,
    input  logic                      dev_finished_i,
    output logic [LEN_W-1:0]          burst_len_o,
    output logic                      dir_to_dev_o,
    output logic [LEN_W-1:0]          xfer_count_o,
    output logic [LEN_W-1:0]          bytes_left_o,
    output logic signed [PHASE_W-1:0] phase_count_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      stat_tc_set_o,
    output logic                      stat_tc_clr_o,
    output logic [7:0]                intr_code_o,
    output logic [NUM_ZERO_REGS-1:0]  zero_regs_o
);
    logic [LEN_W-1:0] dma_len, left_next;
    logic             to_dev, start_acc, burst_acc, phase_next_zero;

    dlc_burst_len #(.BYTE_W(BYTE_W), .PHASE_W(PHASE_W), .CMD_MAX(CMD_MAX)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .tc_lo_i     (tc_lo_i),
        .tc_mid_i    (tc_mid_i),
        .cmd_phase_i (cmd_phase_i),
        .phase_cnt_i (phase_count_o),
        .dma_len_o   (dma_len),
        .burst_len_o (burst_len_o),
        .to_dev_o    (to_dev)
    );

    dlc_counters #(.BYTE_W(BYTE_W), .PHASE_W(PHASE_W)) u_cnt (
        .clk               (clk),
        .rst_n             (rst_n),
        .phase_load_i      (phase_load_i),
        .phase_val_i       (phase_val_i),
        .start_acc_i       (start_acc),
        .burst_acc_i       (burst_acc),
        .dma_len_i         (dma_len),
        .burst_len_i       (burst_len_o),
        .to_dev_i          (to_dev),
        .cmd_i             (cmd_phase_i),
        .step_i            (burst_step_i),
        .xfer_count_o      (xfer_count_o),
        .bytes_left_o      (bytes_left_o),
        .phase_cnt_o       (phase_count_o),
        .dir_to_dev_o      (dir_to_dev_o),
        .left_next_o       (left_next),
        .phase_next_zero_o (phase_next_zero)
    );

    dlc_complete #(.BYTE_W(BYTE_W)) u_cmp (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_i           (start_i),
        .burst_done_i      (burst_done_i),
        .dev_finished_i    (dev_finished_i),
        .dir_to_dev_i      (dir_to_dev_o),
        .left_next_i       (left_next),
        .phase_next_zero_i (phase_next_zero),
        .start_acc_o       (start_acc),
        .burst_acc_o       (burst_acc),
        .busy_o            (busy_o),
        .done_o            (done_o),
        .stat_tc_set_o     (stat_tc_set_o),
        .stat_tc_clr_o     (stat_tc_clr_o),
        .intr_code_o       (intr_code_o),
        .zero_regs_o       (zero_regs_o)
    );

    assert_start_clears_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (stat_tc_clr_o && busy_o));
    assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (!stat_tc_clr_o && xfer_count_o == $past(xfer_count_o)));
endmodule

// File: tb/test_dma_len_ctrl.sv
`timescale 1ns/1ps
module test_dma_len_ctrl;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [7:0]         tc_lo = '0, tc_mid = '0;
    logic               cmd = 1'b0, pload = 1'b0, start = 1'b0, bdone = 1'b0, devfin = 1'b0;
    logic signed [23:0] pval = '0;
    logic [16:0]        step = '0;
    logic [16:0]        burst_len, xfer_count, bytes_left;
    logic               dir, busy, done, tc_set, tc_clr;
    logic signed [23:0] phase_count;
    logic [7:0]         intr_code;
    logic [3:0]         zero_regs;
    int                 errors = 0, checks = 0;

    always #4 clk = ~clk;

    dma_len_ctrl i_dma_len_ctrl (
        .clk(clk), .rst_n(rst_n), .tc_lo_i(tc_lo), .tc_mid_i(tc_mid),
        .cmd_phase_i(cmd), .phase_load_i(pload), .phase_val_i(pval),
        .start_i(start), .burst_done_i(bdone), .burst_step_i(step),
        .dev_finished_i(devfin), .burst_len_o(burst_len), .dir_to_dev_o(dir),
        .xfer_count_o(xfer_count), .bytes_left_o(bytes_left),
        .phase_count_o(phase_count), .busy_o(busy), .done_o(done),
        .stat_tc_set_o(tc_set), .stat_tc_clr_o(tc_clr),
        .intr_code_o(intr_code), .zero_regs_o(zero_regs)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full transfer with bench-computed expectations.
    task automatic run_case(input bit c, input int dma, input int ph, input int sel);
        int exp_burst, mag, st, left, ph_n, cap;
        bit to_dev, imm;
        mag = (ph < 0) ? -ph : ph;
        cap = c ? 32 : mag;
        exp_burst = (dma < cap) ? dma : cap;
        st = (sel == 0) ? exp_burst : (sel == 1) ? ((exp_burst > 0) ? exp_burst - 1 : 0) : exp_burst + 2;
        left = (exp_burst > st) ? exp_burst - st : 0;
        if (c) ph_n = ph;
        else if (st >= mag) ph_n = 0;
        else ph_n = (ph < 0) ? ph + st : ph - st;
        to_dev = c || (ph < 0);
        imm = to_dev || (left != 0) || (ph_n == 0);

        @(negedge clk);
        pload = 1'b1; pval = 24'(ph); cmd = c;
        tc_lo = 8'(dma & 255); tc_mid = 8'((dma >> 8) & 255);
        @(negedge clk);
        pload = 1'b0;
        chk(phase_count == 24'(ph), "R10 phase load", phase_count, ph);
        chk(burst_len == 17'(exp_burst), c ? "R2 cmd burst" : "R3 data burst", burst_len, exp_burst);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(xfer_count == 17'(dma), "R1 dma length", xfer_count, dma);
        chk(bytes_left == 17'(exp_burst) && tc_clr && busy, "R4 start latch", bytes_left, exp_burst);
        chk(dir == to_dev, c ? "R2 direction" : "R3 direction", dir, to_dev);
        bdone = 1'b1; step = 17'(st);
        @(negedge clk);
        bdone = 1'b0;
        chk(bytes_left == 17'(left), "R6 bytes left", bytes_left, left);
        chk(phase_count == 24'(ph_n), "R6 phase step", phase_count, ph_n);
        if (!imm) begin
            chk(done == 1'b0, "R7 deferred", done, 0);
            start = 1'b1; tc_lo = 8'h34; tc_mid = 8'h02;
            @(negedge clk);
            start = 1'b0;
            chk(bytes_left == 17'(left) && xfer_count == 17'(dma) && !tc_clr && !done,
                "R5 busy start ignored", xfer_count, dma);
            devfin = 1'b1;
            @(negedge clk);
            devfin = 1'b0;
        end
        chk(done == 1'b1, "R7 completion due", done, 1);
        chk(tc_set && intr_code == 8'h10 && zero_regs == 4'hF, "R8 completion codes", intr_code, 16);
        @(negedge clk);
        chk(!done && !tc_set && intr_code == 0 && zero_regs == 0 && !busy, "R8 pulse ends", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int dma_tab[6] = '{1, 16, 32, 50, 300, 65536};
        int ph_tab[7]  = '{-70000, -20, -1, 0, 3, 40, 70000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xfer_count == 0 && bytes_left == 0 && phase_count == 0 && !busy && !done
            && !tc_set && !tc_clr && intr_code == 0 && zero_regs == 0, "R9 reset", busy, 0);
        for (int i = 0; i < 6; i++)
            for (int s = 0; s < 3; s++)
                run_case(1'b1, dma_tab[i], 40, s);
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 7; j++)
                for (int s = 0; s < 3; s++)
                    run_case(1'b0, dma_tab[i], ph_tab[j], s);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule